// File: doc/BRIEF.md
# Password Retry Guard

This block caps how many wrong password attempts a secured memory will tolerate. It keeps three pieces of state: an 8-bit attempt limit, an 8-bit attempt counter and a policy byte. Each password-protected transaction begins with a check strobe. The guard then compares the counter with the limit and reports whether the transaction is refused outright, restricted to configuration work, or free to continue. After the password comparator has judged a password, the guard receives one result strobe. A wrong password advances the counter. A correct one may clear it, depending on the policy.

Lockout fires on equality, not on a threshold. A counter loaded above the limit therefore climbs through 255, wraps to 0 and only then reaches the limit. The number of remaining attempts is always (limit - counter) modulo 256. Software loads all three registers through dedicated load strobes. A counter load has priority over a result update in the same cycle.

Top module: `pwd_retry_guard`

## Requirements
- R1: After reset the counter reads 0, the attempt limit is 0, every policy bit is 0, and `full_lock`, `cfg_only_lock` and `refuse` are all 0.
- R2: Policy byte fields are: bit 7 = total-lock select A, bit 6 = total-lock select B, bit 3 = clear-on-success, bit 2 = guard enable. Bits 5, 4, 1 and 0 have no effect.
- R3: With the guard enable bit at 0, a result strobe leaves the counter unchanged and a check strobe reports no lock.
- R4: A check strobe with the guard enable bit at 1 evaluates the lock condition (counter equals limit) from the register values before that clock edge. The lock outputs change on the edge that samples the strobe and hold their value until the next check strobe.
- R5: If the lock condition holds and select A:B = 1:0, the check gives `full_lock`=1, `cfg_only_lock`=0 and `refuse`=1, whatever `cfg_mode` is.
- R6: If the lock condition holds with any other A:B value, the check gives `cfg_only_lock`=1 and `full_lock`=0, and `refuse` equals the inverse of `cfg_mode` sampled with the strobe.
- R7: With the guard enabled, a failing result strobe adds one to the counter modulo 256, so 255 becomes 0.
- R8: With the guard enabled, a passing result strobe clears the counter to 0 when clear-on-success is 1 and leaves it unchanged when that bit is 0.
- R9: Starting from any loaded counter value, exactly (limit - counter) mod 256 failing attempts bring the guard to the lock condition, including when the counter starts above the limit.
- R10: Each result strobe changes the counter at most once. When `ld_count` and a result strobe occur in the same cycle, the counter takes `ld_val` and the result is discarded.
- R11: `ld_limit` loads the limit from `ld_val` and `ld_cfg` loads the policy from `cfg_byte`, each on the next edge. `count_out` always shows the current counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| check_req | input | 1 | Start-of-transaction lock evaluation strobe |
| cfg_mode | input | 1 | The transaction being checked is a configuration operation |
| res_vld | input | 1 | Password result strobe |
| res_pass | input | 1 | Result flag: 1 = password correct |
| ld_count | input | 1 | Load counter from `ld_val` |
| ld_limit | input | 1 | Load attempt limit from `ld_val` |
| ld_cfg | input | 1 | Load policy from `cfg_byte` |
| ld_val | input | 8 | Value for counter or limit loads |
| cfg_byte | input | 8 | Policy byte value |
| full_lock | output | 1 | Last check found a total lockout |
| cfg_only_lock | output | 1 | Last check found a configuration-only lockout |
| refuse | output | 1 | Last checked transaction is refused |
| count_out | output | 8 | Current attempt counter |

## Verification
The assertions check several rules on every cycle. They cover counter arithmetic on result strobes (increment, conditional clear, no change while disabled), priority of a counter load, the two lock outputs never being set together, total lock always implying refusal, and lock outputs holding between check strobes. The bench scenarios cover the rest. These include the decode of the policy byte (including the don't-care bits), the equality comparison against the limit, the mode-dependent refusal under a configuration-only lock, and the wrap-around case where a counter loaded above the limit needs (limit - counter) mod 256 failures before it locks.

// File: rtl/pwd_retry_pkg.sv
package pwd_retry_pkg;

  // policy byte bit positions (decoded by neighbouring logic)
  localparam int SEL_A_BIT = 7;
  localparam int SEL_B_BIT = 6;
  localparam int CLR_BIT   = 3;
  localparam int EN_BIT    = 2;

  typedef struct packed {
    logic sel_a;
    logic sel_b;
    logic clr_ok;
    logic en;
  } policy_t;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_TOTAL = 2'd1,
    LK_CFG   = 2'd2
  } lock_kind_e;

  function automatic policy_t decode_policy(input logic [7:0] b);
    policy_t p;
    p.sel_a  = b[SEL_A_BIT];
    p.sel_b  = b[SEL_B_BIT];
    p.clr_ok = b[CLR_BIT];
    p.en     = b[EN_BIT];
    return p;
  endfunction

  function automatic lock_kind_e classify_lock(input policy_t p, input logic equal);
    if (!p.en || !equal) return LK_NONE;
    if (p.sel_a && !p.sel_b) return LK_TOTAL;
    return LK_CFG;
  endfunction

endpackage

// File: rtl/pwd_retry_regs.sv
module pwd_retry_regs
  import pwd_retry_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_limit,
  input  logic             ld_cfg,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [7:0]       cfg_byte,
  output logic [CNT_W-1:0] limit_q,
  output policy_t          policy_q
);

  // bits of the policy byte that carry no meaning
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_byte[5:4], cfg_byte[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= '0;
      policy_q <= '0;
    end else begin
      if (ld_limit) limit_q  <= ld_val;
      if (ld_cfg)   policy_q <= decode_policy(cfg_byte);
    end
  end

endmodule

// File: rtl/pwd_retry_counter.sv
module pwd_retry_counter
  import pwd_retry_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  policy_t          policy,
  input  logic             res_vld,
  input  logic             res_pass,
  input  logic             ld_count,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count_q,
  output logic             ev_inc,
  output logic             ev_clr
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input policy_t          p,
    input logic             pass
  );
    if (!p.en) return cur;
    if (pass) return p.clr_ok ? '0 : cur;
    return cur + ONE;  // modulo 2**CNT_W
  endfunction

  logic upd;
  assign upd    = res_vld && !ld_count;
  assign ev_inc = upd && policy.en && !res_pass;
  assign ev_clr = upd && policy.en && res_pass && policy.clr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (ld_count) count_q <= ld_val;
    else if (res_vld)  count_q <= next_count(count_q, policy, res_pass);
  end

endmodule

// File: rtl/pwd_retry_lock.sv
module pwd_retry_lock
  import pwd_retry_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_req,
  input  logic             cfg_mode,
  input  policy_t          policy,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] limit,
  output logic             full_lock,
  output logic             cfg_only_lock,
  output logic             refuse,
  output logic             ev_hit
);

  lock_kind_e kind;
  assign ev_hit = (count == limit);
  assign kind   = classify_lock(policy, ev_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_lock     <= 1'b0;
      cfg_only_lock <= 1'b0;
      refuse        <= 1'b0;
    end else if (check_req) begin
      full_lock     <= (kind == LK_TOTAL);
      cfg_only_lock <= (kind == LK_CFG);
      refuse        <= (kind == LK_TOTAL) || ((kind == LK_CFG) && !cfg_mode);
    end
  end

endmodule

// File: rtl/pwd_retry_guard.sv
module pwd_retry_guard
  import pwd_retry_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_req,
  input  logic             cfg_mode,
  input  logic             res_vld,
  input  logic             res_pass,
  input  logic             ld_count,
  input  logic             ld_limit,
  input  logic             ld_cfg,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [7:0]       cfg_byte,
  output logic             full_lock,
  output logic             cfg_only_lock,
  output logic             refuse,
  output logic [CNT_W-1:0] count_out
);

  policy_t          policy;
  logic [CNT_W-1:0] limit_q;
  logic             ev_inc, ev_clr, ev_hit;
  logic             pol_en, pol_clr;

  assign pol_en  = policy.en;
  assign pol_clr = policy.clr_ok;

  pwd_retry_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_limit(ld_limit), .ld_cfg(ld_cfg),
    .ld_val(ld_val), .cfg_byte(cfg_byte), .limit_q(limit_q), .policy_q(policy)
  );

  pwd_retry_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .policy(policy), .res_vld(res_vld),
    .res_pass(res_pass), .ld_count(ld_count), .ld_val(ld_val),
    .count_q(count_out), .ev_inc(ev_inc), .ev_clr(ev_clr)
  );

  pwd_retry_lock #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .check_req(check_req), .cfg_mode(cfg_mode),
    .policy(policy), .count(count_out), .limit(limit_q),
    .full_lock(full_lock), .cfg_only_lock(cfg_only_lock), .refuse(refuse),
    .ev_hit(ev_hit)
  );

endmodule

// File: rtl/pwd_retry_guard_chk.sv
module pwd_retry_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             check_req,
  input logic             res_vld,
  input logic             res_pass,
  input logic             ld_count,
  input logic [CNT_W-1:0] ld_val,
  input logic [CNT_W-1:0] count_out,
  input logic             full_lock,
  input logic             cfg_only_lock,
  input logic             refuse,
  input logic             pol_en,
  input logic             pol_clr,
  input logic             ev_inc
);

  assert_disabled_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_en && !ld_count) |=> $stable(count_out));

  assert_disabled_nolock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (check_req && !pol_en) |=> (!full_lock && !cfg_only_lock));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !check_req |=> ($stable(full_lock) && $stable(cfg_only_lock) && $stable(refuse)));

  assert_total_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_lock |-> refuse);

  assert_lock_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({full_lock, cfg_only_lock}) <= 1);

  assert_fail_increment_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_en && res_vld && !res_pass && !ld_count) |=>
      (count_out == CNT_W'($past(count_out) + CNT_W'(1))));

  assert_pass_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_en && res_vld && res_pass && pol_clr && !ld_count) |=> (count_out == '0));

  assert_pass_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_pass && !pol_clr && !ld_count) |=> $stable(count_out));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_count |=> (count_out == $past(ld_val)));

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inc |-> (res_vld && !ld_count));

endmodule

bind pwd_retry_guard pwd_retry_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .check_req(check_req), .res_vld(res_vld),
  .res_pass(res_pass), .ld_count(ld_count), .ld_val(ld_val),
  .count_out(count_out), .full_lock(full_lock), .cfg_only_lock(cfg_only_lock),
  .refuse(refuse), .pol_en(pol_en), .pol_clr(pol_clr), .ev_inc(ev_inc)
);

// File: tb/pwd_retry_guard_bench.sv
module pwd_retry_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       check_req = 0, cfg_mode = 0, res_vld = 0, res_pass = 0;
  logic       ld_count = 0, ld_limit = 0, ld_cfg = 0;
  logic [7:0] ld_val = 0, cfg_byte = 0;
  logic       full_lock, cfg_only_lock, refuse;
  logic [7:0] count_out;

  always #10 clk = ~clk;  // 50 MHz

  pwd_retry_guard u_pwd_retry_guard (
    .clk(clk), .rst_n(rst_n), .check_req(check_req), .cfg_mode(cfg_mode),
    .res_vld(res_vld), .res_pass(res_pass), .ld_count(ld_count),
    .ld_limit(ld_limit), .ld_cfg(ld_cfg), .ld_val(ld_val), .cfg_byte(cfg_byte),
    .full_lock(full_lock), .cfg_only_lock(cfg_only_lock), .refuse(refuse),
    .count_out(count_out)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       full;
    logic       cfgo;
    logic       refu;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // reference state, kept from the requirement text
  logic [7:0] m_cnt = 0, m_lim = 0, m_pol = 0;
  logic       m_full = 0, m_cfgo = 0, m_ref = 0;

  task automatic cyc(input logic c_req, input logic c_mode, input logic vld,
                     input logic pass, input logic lc, input logic ll,
                     input logic lf, input logic [7:0] val,
                     input logic [7:0] cb, input string tag);
    logic en, clr, sa, sb, hit;
    exp_t e;
    @(negedge clk);
    check_req = c_req; cfg_mode = c_mode; res_vld = vld; res_pass = pass;
    ld_count = lc; ld_limit = ll; ld_cfg = lf; ld_val = val; cfg_byte = cb;
    en = m_pol[2]; clr = m_pol[3]; sa = m_pol[7]; sb = m_pol[6];
    if (c_req) begin
      hit    = en && (m_cnt == m_lim);
      m_full = hit && sa && !sb;
      m_cfgo = hit && !(sa && !sb);
      m_ref  = m_full || (m_cfgo && !c_mode);
    end
    if (lc) m_cnt = val;
    else if (vld && en) m_cnt = pass ? (clr ? 8'd0 : m_cnt) : m_cnt + 8'd1;
    if (ll) m_lim = val;
    if (lf) m_pol = cb;
    @(posedge clk);
    #1;
    e.cnt = m_cnt; e.full = m_full; e.cfgo = m_cfgo; e.refu = m_ref; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);   cyc(0,0,0,0,0,0,0,8'd0,8'd0,tag); endtask
  task automatic set_pol(input logic [7:0] b, input string tag); cyc(0,0,0,0,0,0,1,8'd0,b,tag); endtask
  task automatic set_lim(input logic [7:0] v, input string tag); cyc(0,0,0,0,0,1,0,v,8'd0,tag); endtask
  task automatic set_cnt(input logic [7:0] v, input string tag); cyc(0,0,0,0,1,0,0,v,8'd0,tag); endtask
  task automatic fail_pw(input string tag); cyc(0,0,1,0,0,0,0,8'd0,8'd0,tag); endtask
  task automatic pass_pw(input string tag); cyc(0,0,1,1,0,0,0,8'd0,8'd0,tag); endtask
  task automatic check(input logic m, input string tag); cyc(1,m,0,0,0,0,0,8'd0,8'd0,tag); endtask

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (count_out !== e.cnt || full_lock !== e.full ||
          cfg_only_lock !== e.cfgo || refuse !== e.refu) begin
        bad++;
        $display("FAIL %s: got cnt=%0d full=%b cfgo=%b ref=%b exp cnt=%0d full=%b cfgo=%b ref=%b",
                 e.tag, count_out, full_lock, cfg_only_lock, refuse,
                 e.cnt, e.full, e.cfgo, e.refu);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r.cnt = 0; r.full = 0; r.cfgo = 0; r.refu = 0; r.tag = "R1 reset";
    q.push_back(r);
    idle("R1 idle after reset");

    // R3: enable off, counter equals limit (both 0) yet no lock
    check(0, "R3 no lock when disabled");
    fail_pw("R3 fail ignored when disabled");
    fail_pw("R3 fail ignored again");

    // R2 don't-care bits only: still disabled
    set_pol(8'h33, "R2 junk bits load");
    fail_pw("R2 junk bits do not enable");
    check(0, "R2 junk bits no lock");

    // R7/R6: enabled, clear-on-success, A:B=00
    set_pol(8'h0C, "R11 policy load");
    set_lim(8'd3, "R11 limit load");
    fail_pw("R7 inc 1");
    fail_pw("R7 inc 2");
    check(0, "R4 not yet equal");
    fail_pw("R7 inc 3");
    check(0, "R6 cfg-only lock refuses normal op");
    idle("R4 lock held");
    check(1, "R6 cfg-only lock admits config op");
    pass_pw("R8 pass clears");
    check(0, "R4 unlocked after clear");

    // R8: clear-on-success off, with don't-care bits set (R2)
    set_pol(8'h37, "R2 enable with junk bits");
    fail_pw("R7 inc after junk policy");
    pass_pw("R8 pass keeps count");

    // R5: total lock
    set_pol(8'h84, "R5 select total");
    set_cnt(8'd3, "R11 counter load");
    check(1, "R5 total lock refuses config op");
    check(0, "R5 total lock refuses normal op");

    // A:B=11 gives config-only
    set_pol(8'hC4, "R6 select 11");
    check(1, "R6 11 is cfg-only");

    // R9 wrap: count 250, limit 3 -> 9 failures
    set_pol(8'h04, "R9 policy");
    set_cnt(8'd250, "R9 preload above limit");
    for (int i = 0; i < 8; i++) fail_pw("R9 wrap fail step");
    check(0, "R9 not locked after 8");
    fail_pw("R9 ninth fail");
    check(0, "R9 locked after 9");

    // R7 wrap 255 -> 0
    set_cnt(8'd255, "R7 preload 255");
    fail_pw("R7 255 wraps to 0");

    // R10: load and result same cycle
    cyc(0,0,1,0,1,0,0,8'd10,8'd0,"R10 load beats fail");
    cyc(0,0,1,1,1,0,1,8'd20,8'h0C,"R10 load beats pass");
    pass_pw("R8 pass clears after R10");

    idle("final drain");
    idle("final drain 2");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule